// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit examines one bit of a data operand and can change that same bit in the same pass. A second input gives the bit position. A two-bit operation select chooses what happens to the bit: it is only read, set to 1, cleared to 0, or inverted. The carry output always gives the value the selected bit had before any change, so a single pass acts as an atomic read-modify of that bit.

A size select picks between a 16-bit and a 32-bit operand. In 16-bit mode the upper half of the operand is ignored and the upper half of the result is zero. The bit position wraps modulo the operand size. The unit takes one operation per cycle and has no handshake. A parameter chooses whether the result is registered, with one cycle of latency (the default), or comes out combinationally.

Top module: `bit_modify_unit`

## Requirements
- R1: Operation code 2'b00 (test) returns the size-clipped operand unchanged and drives the carry with the selected bit.
- R2: Operation code 2'b01 (set) returns the size-clipped operand with the selected bit forced to 1 and every other bit unchanged.
- R3: Operation code 2'b10 (reset) returns the size-clipped operand with the selected bit forced to 0 and every other bit unchanged.
- R4: Operation code 2'b11 (complement) returns the size-clipped operand with only the selected bit inverted.
- R5: For every operation, the carry equals the selected bit's value before modification.
- R6: The bit position is the index input modulo the operand size: index bits [3:0] in 16-bit mode and bits [4:0] in 32-bit mode. Higher index bits have no effect.
- R7: When in_wide is 0 (16-bit mode), operand bits [31:16] do not affect the carry or the result, and result bits [31:16] are zero. When in_wide is 1, the full 32 bits are used.
- R8: With the registered variant, the result and carry of inputs presented in one cycle appear after the next rising clock edge. While rst_n is low, the result and carry are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| in_data | input | 32 | Data operand |
| in_index | input | 8 | Bit position (taken modulo the operand size) |
| in_op | input | 2 | Operation: 00 test, 01 set, 10 reset, 11 complement |
| in_wide | input | 1 | 1 selects 32-bit operand, 0 selects 16-bit operand |
| out_data | output | 32 | Operand, possibly with the selected bit modified |
| out_carry | output | 1 | Value of the selected bit before modification |

## Verification
The hardest situation to reach is 16-bit mode when both the upper operand half and the upper index bits hold non-zero values. Only there does a wrong wrap of the index or a leak of the upper half show up. The stimulus sweeps every bit index at both sizes, with all four operations and random operands. Each index gets random upper index bits, so every position is reached through many aliased index values while the upper operand half is filled with random data.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int BM_OP_W = 2;

    typedef enum logic [BM_OP_W-1:0] {
        BM_TEST = 2'b00,
        BM_SET  = 2'b01,
        BM_CLR  = 2'b10,
        BM_FLIP = 2'b11
    } bm_op_e;
endpackage

// File: rtl/bm_operand_clip.sv
// Narrows the operand to the selected size, zero-filling the upper part (R7).
module bm_operand_clip #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] clip_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b < NARROW_W) begin : g_low
            assign clip_o[b] = data_i[b];
        end else begin : g_high
            assign clip_o[b] = data_i[b] & wide_i;
        end
    end
endmodule

// File: rtl/bm_index_decode.sv
// Wraps the index modulo the operand size and builds a one-hot bit mask (R6).
module bm_index_decode #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int IDX_W    = 8
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] mask_o
);
    localparam int POS_W  = $clog2(DATA_W);
    localparam int NPOS_W = $clog2(NARROW_W);

    logic [POS_W-1:0] pos;

    always_comb begin
        pos = '0;
        if (wide_i) begin
            pos = idx_i[POS_W-1:0];
        end else begin
            pos[NPOS_W-1:0] = idx_i[NPOS_W-1:0];
        end
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        assign mask_o[b] = (pos == POS_W'(b));
    end
endmodule

// File: rtl/bm_modify.sv
// Samples the selected bit and applies the chosen change to it (R1..R5).
module bm_modify
    import bm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]  src_i,
    input  logic [DATA_W-1:0]  mask_i,
    input  logic [BM_OP_W-1:0] op_i,
    output logic [DATA_W-1:0]  res_o,
    output logic               carry_o
);
    bm_op_e op;

    always_comb begin
        op      = bm_op_e'(op_i);
        carry_o = |(src_i & mask_i);
        unique case (op)
            BM_TEST: res_o = src_i;
            BM_SET:  res_o = src_i | mask_i;
            BM_CLR:  res_o = src_i & ~mask_i;
            BM_FLIP: res_o = src_i ^ mask_i;
            default: res_o = src_i;
        endcase
    end
endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
    import bm_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NARROW_W   = 16,
    parameter int IDX_W      = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [IDX_W-1:0]   in_index,
    input  logic [BM_OP_W-1:0] in_op,
    input  logic               in_wide,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_carry
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              carry;
    } bm_out_t;

    logic [DATA_W-1:0] clip;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] mod_res;
    logic              mod_carry;
    bm_out_t           nxt_d;

    bm_operand_clip #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_clip (
        .data_i (in_data),
        .wide_i (in_wide),
        .clip_o (clip)
    );

    bm_index_decode #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)) u_dec (
        .idx_i  (in_index),
        .wide_i (in_wide),
        .mask_o (mask)
    );

    bm_modify #(.DATA_W(DATA_W)) u_mod (
        .src_i   (clip),
        .mask_i  (mask),
        .op_i    (in_op),
        .res_o   (mod_res),
        .carry_o (mod_carry)
    );

    always_comb begin
        nxt_d.data  = mod_res;
        nxt_d.carry = mod_carry;
    end

    if (REGISTERED) begin : g_reg
        bm_out_t out_q;
        logic    live_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q  <= '0;
                live_q <= 1'b0;
            end else begin
                out_q  <= nxt_d;
                live_q <= 1'b1;
            end
        end

        assign out_data  = out_q.data;
        assign out_carry = out_q.carry;

        // R1: test leaves the clipped operand untouched
        a_r1_test_passthru: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(in_op) == BM_TEST) |-> out_data == $past(clip));

        // R2: set only adds one bit
        a_r2_set_grows: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(in_op) == BM_SET) |->
                ((out_data & $past(clip)) == $past(clip)) &&
                ($countones(out_data ^ $past(clip)) <= 1));

        // R3: reset only removes one bit
        a_r3_clr_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(in_op) == BM_CLR) |->
                ((out_data & ~$past(clip)) == '0) &&
                ($countones(out_data ^ $past(clip)) <= 1));

        // R4: complement always changes exactly one bit
        a_r4_flip_one: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(in_op) == BM_FLIP) |->
                $countones(out_data ^ $past(clip)) == 1);

        // R5: for set the carry is 1 exactly when nothing changed
        a_r5_carry_before: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(in_op) == BM_SET) |->
                (out_carry == (out_data == $past(clip))));

        // R7: narrow mode yields a zero upper half
        a_r7_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && !$past(in_wide)) |-> out_data[DATA_W-1:NARROW_W] == '0);
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign out_data   = nxt_d.data;
        assign out_carry  = nxt_d.carry;
    end
endmodule

// File: tb/sim_bit_modify_unit.sv
`timescale 1ns/1ps
module sim_bit_modify_unit;
    localparam int DW = 32;
    localparam int IW = 8;
    localparam int NV = 13;
    localparam int VW = 76;
    localparam int WATCHDOG_CYC = 200000;

    // {data[75:44], index[43:36], op[35:34], wide[33], exp_data[32:1], exp_carry[0]}
    localparam logic [VW-1:0] VEC [NV] = '{
        {32'hA5A5_0F0F, 8'd0,   2'b00, 1'b1, 32'hA5A5_0F0F, 1'b1},
        {32'hA5A5_0F0F, 8'd4,   2'b01, 1'b1, 32'hA5A5_0F1F, 1'b0},
        {32'hFFFF_FFFF, 8'd31,  2'b10, 1'b1, 32'h7FFF_FFFF, 1'b1},
        {32'h0000_0000, 8'd31,  2'b11, 1'b1, 32'h8000_0000, 1'b0},
        {32'h8000_0001, 8'd31,  2'b11, 1'b1, 32'h0000_0001, 1'b1},
        {32'h1234_5678, 8'd16,  2'b01, 1'b0, 32'h0000_5679, 1'b0},
        {32'hFFFF_0000, 8'd15,  2'b00, 1'b0, 32'h0000_0000, 1'b0},
        {32'hFFFF_8000, 8'd15,  2'b10, 1'b0, 32'h0000_0000, 1'b1},
        {32'h0000_0001, 8'h20,  2'b10, 1'b1, 32'h0000_0000, 1'b1},
        {32'h0000_0001, 8'hE1,  2'b01, 1'b1, 32'h0000_0003, 1'b0},
        {32'hDEAD_BEEF, 8'h13,  2'b11, 1'b0, 32'h0000_BEE7, 1'b1},
        {32'h0000_0040, 8'd6,   2'b01, 1'b1, 32'h0000_0040, 1'b1},
        {32'h0000_BFFF, 8'd14,  2'b10, 1'b0, 32'h0000_BFFF, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [IW-1:0] in_index = '0;
    logic [1:0]    in_op = '0;
    logic          in_wide = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_carry;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bit_modify_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_index  (in_index),
        .in_op     (in_op),
        .in_wide   (in_wide),
        .out_data  (out_data),
        .out_carry (out_carry)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference: written from the requirements with arithmetic modulo.
    task automatic model(input logic [DW-1:0] d, input logic [IW-1:0] idx,
                         input logic [1:0] op, input logic wide,
                         output logic [DW-1:0] r, output logic c);
        int size = wide ? 32 : 16;
        int p = int'(idx) % size;
        logic [DW-1:0] s = d;
        if (!wide) s[31:16] = 16'h0;
        c = s[p];
        r = s;
        case (op)
            2'b01: r[p] = 1'b1;
            2'b10: r[p] = 1'b0;
            2'b11: r[p] = ~s[p];
            default: r = s;
        endcase
    endtask

    task automatic apply(input logic [DW-1:0] d, input logic [IW-1:0] idx,
                         input logic [1:0] op, input logic wide);
        @(negedge clk);
        in_data = d; in_index = idx; in_op = op; in_wide = wide;
        @(negedge clk);
    endtask

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R1 test";
            2'b01: return "R2 set";
            2'b10: return "R3 reset";
            default: return "R4 complement";
        endcase
    endfunction

    task automatic run_all();
        logic [DW-1:0] er;
        logic          ec;
        // R8: reset state
        repeat (2) @(negedge clk);
        check(out_data == '0 && out_carry == 1'b0, "R8 reset state",
              {out_data, out_carry}, '0);
        @(negedge clk); rst_n = 1'b1;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][75:44], VEC[v][43:36], VEC[v][35:34], VEC[v][33]);
            check(out_data == VEC[v][32:1], $sformatf("%s data (R6/R7) vec %0d", op_tag(VEC[v][35:34]), v),
                  {1'b0, out_data}, {1'b0, VEC[v][32:1]});
            check(out_carry == VEC[v][0], $sformatf("R5 carry vec %0d", v),
                  {32'h0, out_carry}, {32'h0, VEC[v][0]});
        end

        // Sweep: every index at both sizes, all ops, random operand and upper index bits
        for (int w = 0; w < 2; w++) begin
            for (int op = 0; op < 4; op++) begin
                for (int p = 0; p < (w ? 32 : 16); p++) begin
                    logic [DW-1:0] d = $urandom;
                    logic [IW-1:0] idx = IW'(p) + IW'(($urandom % 8) * (w ? 32 : 16));
                    apply(d, idx, 2'(op), w[0]);
                    model(d, idx, 2'(op), w[0], er, ec);
                    check(out_data == er && out_carry == ec,
                          $sformatf("%s R5 R6 R7 sweep w=%0d p=%0d", op_tag(2'(op)), w, p),
                          {out_data, out_carry}, {er, ec});
                end
            end
        end

        // R8: output holds until the clock edge, then updates
        apply(32'h0000_00F0, 8'd4, 2'b10, 1'b1);
        check(out_data == 32'h0000_00E0 && out_carry, "R8 first result",
              {out_data, out_carry}, {32'h0000_00E0, 1'b1});
        in_data = 32'h0000_0000; in_index = 8'd0; in_op = 2'b11; in_wide = 1'b1;
        #2;
        check(out_data == 32'h0000_00E0 && out_carry, "R8 holds before edge",
              {out_data, out_carry}, {32'h0000_00E0, 1'b1});
        @(negedge clk);
        check(out_data == 32'h0000_0001 && !out_carry, "R8 updates after edge",
              {out_data, out_carry}, {32'h0000_0001, 1'b0});

        // R8: reset mid-run clears the result
        rst_n = 1'b0;
        in_data = 32'hFFFF_FFFF; in_op = 2'b00; in_index = 8'd3;
        @(negedge clk);
        check(out_data == '0 && !out_carry, "R8 reset clears",
              {out_data, out_carry}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_data == 32'hFFFF_FFFF && out_carry, "R1 after reset release",
              {out_data, out_carry}, {32'hFFFF_FFFF, 1'b1});
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WATCHDOG_CYC) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule